// File: doc/BRIEF.md
# Receiver Reset and Lock Sequencer

This block brings a deserializing receive path out of reset in a fixed order. It drives three reset lines: one for the clock synthesizer (PLL), one for the dynamic phase alignment circuit (DPA), and one for the receive FIFO. It watches two status inputs, PLL lock and DPA lock. The PLL leaves reset first. The DPA is freed only after the PLL lock has held for a set number of cycles. The FIFO gets a reset pulse once the DPA reports lock. When all three steps are done, a ready output rises.

Both lock inputs pass through two-flop synchronizers before any decision uses them. If the PLL loses lock at any point after its reset has been released, the whole sequence starts again. If the DPA loses lock while running, or fails to lock within a timeout, only the DPA step is repeated. A timeout also sets a sticky error flag. The active-low asynchronous reset `rst_ni` is the master reset and forces the initial step.

Top module: `rx_lock_seq`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `pll_rst_o` and `dpa_rst_o` are 1, and `fifo_rst_o`, `ready_o` and `dpa_err_o` are 0.
- R2: One cycle after the initial step, `pll_rst_o` goes to 0 while `dpa_rst_o` stays 1. `dpa_rst_o` is 1 whenever `pll_rst_o` is 1.
- R3: `dpa_rst_o` is released only after the synchronized PLL lock has been 1 for `STABLE_CYCLES` consecutive cycles. A single low cycle sets that count back to zero.
- R4: A change on `pll_lock_i` or `dpa_lock_i` affects the decisions through exactly two synchronizer flops.
- R5: When the synchronized DPA lock is 1 while the block waits for it, `fifo_rst_o` goes high for exactly `FIFO_PULSE` cycles (minimum 1). It then falls and the block enters the run step. It is never cut short except by a PLL lock loss.
- R6: A low synchronized PLL lock in the DPA wait, DPA re-reset, FIFO reset or run step returns the block to the initial step on the next cycle.
- R7: If the synchronized DPA lock stays low for `DPA_TIMEOUT` cycles of DPA waiting, `dpa_err_o` is set and stays set until `rst_ni`. `dpa_rst_o` is reasserted for one cycle, and the wait then restarts.
- R8: `ready_o` is 1 only in the run step while both synchronized locks are 1. It is 0 in the same cycle that a restart is triggered.
- R9: A low synchronized DPA lock in the run step reasserts `dpa_rst_o` for one cycle on the next cycle, while `pll_rst_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel (slow) clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| pll_lock_i | input | 1 | PLL lock status, asynchronous |
| dpa_lock_i | input | 1 | DPA lock status, asynchronous |
| pll_rst_o | output | 1 | PLL reset, active high |
| dpa_rst_o | output | 1 | DPA reset, active high |
| fifo_rst_o | output | 1 | Receive FIFO reset, active high |
| ready_o | output | 1 | Receive path usable |
| dpa_err_o | output | 1 | Sticky DPA lock timeout flag |

## Verification
The bench brings the path up in several ways:
- With a clean PLL lock.
- With a one-cycle PLL glitch during qualification, which separates a consecutive-cycle count from a cumulative one.
- With a DPA that never locks in time, which exercises the timeout, the sticky flag and the DPA-only retry.
- With lock losses injected during the DPA wait, during the FIFO pulse and during run, which show whether a PLL loss restarts everything while a DPA loss repeats only the DPA step.

A behavioural model is compared with every output on every cycle. A separate monitor measures each FIFO reset pulse width.

// File: rtl/rx_lock_seq_pkg.sv
package rx_lock_seq_pkg;
  typedef enum logic [2:0] {
    ST_RST_ALL  = 3'd0,
    ST_PLL_WAIT = 3'd1,
    ST_DPA_WAIT = 3'd2,
    ST_DPA_RST  = 3'd3,
    ST_FIFO_RST = 3'd4,
    ST_RUN      = 3'd5
  } seq_state_e;
endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier #(
  parameter int STABLE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic lock_i,
  output logic stable_o
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  logic [CW-1:0] run_q;

  assign stable_o = enable_i && lock_i && (run_q == CW'(STABLE_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   run_q <= '0;
    else if (!enable_i || !lock_i) run_q <= '0;
    else if (!stable_o)            run_q <= run_q + 1'b1;
  end
endmodule

// File: rtl/step_timer.sv
module step_timer #(
  parameter int LIMIT = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       count_i,
  output logic [$clog2(LIMIT+1)-1:0] value_o
);
  localparam int TW = $clog2(LIMIT + 1);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      value_o <= '0;
    else if (clear_i) value_o <= '0;
    else if (count_i && value_o != TW'(LIMIT)) value_o <= value_o + 1'b1;
  end
endmodule

// File: rtl/rx_lock_seq.sv
module rx_lock_seq
  import rx_lock_seq_pkg::*;
#(
  parameter int STABLE_CYCLES = 16,
  parameter int DPA_TIMEOUT   = 64,
  parameter int FIFO_PULSE    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pll_lock_i,
  input  logic dpa_lock_i,
  output logic pll_rst_o,
  output logic dpa_rst_o,
  output logic fifo_rst_o,
  output logic ready_o,
  output logic dpa_err_o
);
  localparam int PULSE   = (FIFO_PULSE < 1) ? 1 : FIFO_PULSE;
  localparam int T_LIMIT = (DPA_TIMEOUT > PULSE) ? DPA_TIMEOUT : PULSE;
  localparam int TW      = $clog2(T_LIMIT + 1);

  seq_state_e state_q, state_d;
  logic [1:0] lock_s;
  logic       pll_s, dpa_s, pll_stable, err_set;
  logic [TW-1:0] tmr;

  lock_sync #(.WIDTH(2), .STAGES(2)) i_sync (
    .clk_i, .rst_ni,
    .async_i({dpa_lock_i, pll_lock_i}),
    .sync_o (lock_s)
  );
  assign pll_s = lock_s[0];
  assign dpa_s = lock_s[1];

  lock_qualifier #(.STABLE_CYCLES(STABLE_CYCLES)) i_qual (
    .clk_i, .rst_ni,
    .enable_i(state_q == ST_PLL_WAIT),
    .lock_i  (pll_s),
    .stable_o(pll_stable)
  );

  step_timer #(.LIMIT(T_LIMIT)) i_tmr (
    .clk_i, .rst_ni,
    .clear_i(state_d != state_q),
    .count_i(state_q == ST_DPA_WAIT || state_q == ST_FIFO_RST),
    .value_o(tmr)
  );

  always_comb begin
    state_d = state_q;
    err_set = 1'b0;
    unique case (state_q)
      ST_RST_ALL:  state_d = ST_PLL_WAIT;
      ST_PLL_WAIT: if (pll_stable) state_d = ST_DPA_WAIT;
      ST_DPA_WAIT: begin
        if (!pll_s)     state_d = ST_RST_ALL;
        else if (dpa_s) state_d = ST_FIFO_RST;
        else if (tmr == TW'(DPA_TIMEOUT - 1)) begin
          state_d = ST_DPA_RST;
          err_set = 1'b1;
        end
      end
      ST_DPA_RST:  state_d = pll_s ? ST_DPA_WAIT : ST_RST_ALL;
      ST_FIFO_RST: begin
        if (!pll_s)                       state_d = ST_RST_ALL;
        else if (tmr == TW'(PULSE - 1))   state_d = ST_RUN;
      end
      ST_RUN: begin
        if (!pll_s)      state_d = ST_RST_ALL;
        else if (!dpa_s) state_d = ST_DPA_RST;
      end
      default:     state_d = ST_RST_ALL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RST_ALL;
      dpa_err_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      if (err_set) dpa_err_o <= 1'b1;
    end
  end

  assign pll_rst_o  = (state_q == ST_RST_ALL);
  assign dpa_rst_o  = (state_q == ST_RST_ALL) || (state_q == ST_PLL_WAIT) || (state_q == ST_DPA_RST);
  assign fifo_rst_o = (state_q == ST_FIFO_RST);
  // drops combinationally with the restart condition
  assign ready_o    = (state_q == ST_RUN) && pll_s && dpa_s;

  // assertions
  int unsigned pulse_seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pulse_seen <= 0;
    else if (fifo_rst_o) pulse_seen <= pulse_seen + 1;
    else                 pulse_seen <= 0;
  end

  a_r2_dpa_held_with_pll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_rst_o |-> dpa_rst_o);
  a_r5_fifo_min_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(fifo_rst_o) && !pll_rst_o) |-> (pulse_seen >= PULSE));
  a_r6_pll_loss_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pll_s && !pll_rst_o && !(dpa_rst_o && !pll_rst_o && state_q == ST_PLL_WAIT)) |=> pll_rst_o);
  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dpa_err_o |=> dpa_err_o);
  a_r8_ready_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!pll_rst_o && !dpa_rst_o && !fifo_rst_o && pll_s && dpa_s));
endmodule

// File: tb/test_rx_lock_seq.sv
module test_rx_lock_seq;
  localparam int STABLE = 8;
  localparam int TMO    = 20;
  localparam int PULSE  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pll_lock = 1'b0;
  logic dpa_lock;
  logic pll_rst, dpa_rst, fifo_rst, ready, dpa_err;

  int checks = 0, failures = 0, cycles = 0;
  int dpa_delay = 3;
  bit dpa_kill = 1'b0;
  int dpa_cnt = 0;

  always #2 clk = ~clk;

  rx_lock_seq #(.STABLE_CYCLES(STABLE), .DPA_TIMEOUT(TMO), .FIFO_PULSE(PULSE)) i_rx_lock_seq (
    .clk_i(clk), .rst_ni(rst_n), .pll_lock_i(pll_lock), .dpa_lock_i(dpa_lock),
    .pll_rst_o(pll_rst), .dpa_rst_o(dpa_rst), .fifo_rst_o(fifo_rst),
    .ready_o(ready), .dpa_err_o(dpa_err)
  );

  // DPA responder
  always @(posedge clk) begin
    #1;
    if (dpa_rst) dpa_cnt = 0;
    else if (dpa_cnt < 100000) dpa_cnt++;
  end
  assign dpa_lock = !dpa_rst && (dpa_cnt >= dpa_delay) && !dpa_kill;

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // reference model: 0 all-reset, 1 pll wait, 2 dpa wait, 3 dpa re-reset, 4 fifo reset, 5 run
  int m_st = 0, m_stab = 0, m_tm = 0;
  bit m_p1 = 0, m_p2 = 0, m_d1 = 0, m_d2 = 0, m_err = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_stab = 0; m_tm = 0; m_err = 0;
      m_p1 = 0; m_p2 = 0; m_d1 = 0; m_d2 = 0;
    end else begin
      int ns;
      ns = m_st;
      case (m_st)
        0: ns = 1;
        1: if (!m_p2) m_stab = 0;
           else if (m_stab == STABLE - 1) ns = 2;
           else m_stab++;
        2: if (!m_p2) ns = 0;
           else if (m_d2) ns = 4;
           else if (m_tm == TMO - 1) begin ns = 3; m_err = 1; end
           else m_tm++;
        3: ns = m_p2 ? 2 : 0;
        4: if (!m_p2) ns = 0;
           else if (m_tm == PULSE - 1) ns = 5;
           else m_tm++;
        5: if (!m_p2) ns = 0;
           else if (!m_d2) ns = 3;
        default: ns = 0;
      endcase
      if (ns != m_st) begin m_tm = 0; m_stab = 0; end
      m_st = ns;
      m_p2 = m_p1; m_p1 = pll_lock;
      m_d2 = m_d1; m_d1 = dpa_lock;
    end
  end

  // per-cycle comparison, away from the rising edge
  int pw = 0;
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R2 R6", pll_rst, m_st == 0, "pll_rst_o");
      check("R3 R4 R9", dpa_rst, (m_st <= 1) || (m_st == 3), "dpa_rst_o");
      check("R5", fifo_rst, m_st == 4, "fifo_rst_o");
      check("R8", ready, (m_st == 5) && m_p2 && m_d2, "ready_o");
      check("R7", dpa_err, m_err, "dpa_err_o");
      if (fifo_rst) pw++;
      else begin
        if (pw != 0 && !pll_rst) begin
          checks++;
          if (pw != PULSE) begin
            failures++;
            $display("FAIL R5 fifo pulse width actual=%0d expected=%0d", pw, PULSE);
          end
        end
        pw = 0;
      end
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_ready(input string req);
    int k;
    for (k = 0; k < 400 && !ready; k++) step(1);
    check(req, ready, 1'b1, "ready_o reached");
  endtask

  task automatic check_reset_state();
    check("R1", pll_rst, 1'b1, "pll_rst_o at reset");
    check("R1", dpa_rst, 1'b1, "dpa_rst_o at reset");
    check("R1", fifo_rst, 1'b0, "fifo_rst_o at reset");
    check("R1", ready, 1'b0, "ready_o at reset");
    check("R1", dpa_err, 1'b0, "dpa_err_o at reset");
  endtask

  initial begin
    step(3);
    check_reset_state();
    rst_n = 1'b1;
    check_reset_state();
    step(1);
    check("R2", pll_rst, 1'b0, "pll_rst_o released");
    check("R2", dpa_rst, 1'b1, "dpa_rst_o held");

    // R3: glitch during qualification
    pll_lock = 1'b1; step(5);
    pll_lock = 1'b0; step(1);
    pll_lock = 1'b1; step(STABLE);
    check("R3", dpa_rst, 1'b1, "dpa_rst_o held after glitch");
    wait_ready("R5");
    step(10);

    // R9: DPA lock loss in run
    dpa_kill = 1'b1; step(5);
    check("R9", pll_rst, 1'b0, "pll_rst_o untouched on dpa loss");
    dpa_kill = 1'b0;
    wait_ready("R9");

    // R6: PLL loss in run
    pll_lock = 1'b0; step(3);
    check("R6", ready, 1'b0, "ready_o after pll loss");
    pll_lock = 1'b1;
    wait_ready("R6");

    // R7: DPA timeout
    dpa_delay = 100;
    pll_lock = 1'b0; step(3); pll_lock = 1'b1;
    step(STABLE + TMO + 10);
    check("R7", dpa_err, 1'b1, "dpa_err_o after timeout");
    dpa_delay = 3;
    wait_ready("R7");
    check("R7", dpa_err, 1'b1, "dpa_err_o sticky");

    // R6: PLL loss during FIFO reset pulse
    dpa_kill = 1'b1; step(1);
    while (!dpa_rst) step(1);
    dpa_kill = 1'b0;
    while (!fifo_rst) step(1);
    pll_lock = 1'b0; step(4);
    check("R6", pll_rst, 1'b0, "sequence restarted");
    pll_lock = 1'b1;
    wait_ready("R6");

    // R6: PLL loss during DPA wait
    dpa_delay = 100;
    pll_lock = 1'b0; step(3); pll_lock = 1'b1;
    while (dpa_rst) step(1);
    step(5);
    pll_lock = 1'b0; step(4);
    pll_lock = 1'b1; dpa_delay = 2;
    wait_ready("R6");

    // R1: master reset mid-run clears the error flag
    rst_n = 1'b0; step(1);
    check_reset_state();
    rst_n = 1'b1;
    wait_ready("R1");
    step(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule